// File: doc/BRIEF.md
# Keyboard Transfer Handshake with Auto-Repeat

This block sits between a parallel keyboard and a CPU that polls its devices. When the keyboard has a character it raises a strobe. On a poll the block claims the transfer and puts its own device address on the data bus. A CPU data strobe then moves the key code onto the bus and sends an acknowledge back to the keyboard. The acknowledge stays up until the keyboard drops its strobe, and that drop returns the handshake to idle.

The strobe drop also starts a hold-off timer, half a second at the default settings. If the timer runs out with no other transfer, a repeat-enable flag is set. That flag runs a 15 Hz divider. Each divider tick goes through a three-stage shift register. When it leaves the last stage it posts a repeat request. The CPU then collects the stored character again through the same poll and data-strobe sequence, and no acknowledge goes to the keyboard. Both timer lengths are computed from a clock-frequency parameter. The bus is modelled as a value plus a drive-enable flag.

The handshake uses plain level pins with no valid/ready flow control. The bus is driven only in its address and data phases. No transfer is lost, because a waiting character is held until the CPU completes the sequence.

Top module: `kbd_autorepeat`

## Requirements
- R1: After reset the bus drive-enable and the keyboard acknowledge are both 0.
- R2: A poll with no character waiting and no repeat request is ignored: the bus drive-enable stays 0.
- R3: A poll while the keyboard strobe is high claims the transfer. From the next cycle the bus is driven (enable 1) with the device address `DEV_ADDR` (default 8'h2C).
- R4: After a claim, the address stays on the bus for as long as the CPU data strobe stays low.
- R5: A CPU data strobe after a keyboard claim drives the latched key code on the bus from the next cycle and raises the keyboard acknowledge.
- R6: When the CPU data strobe falls, the bus is released. The acknowledge stays at 1 until the keyboard strobe is low, and falls in the cycle after that.
- R7: No repeat is offered before the hold-off time (`CLK_HZ/HOLD_DIV` cycles) has passed since the keyboard strobe fell.
- R8: Once the hold-off has expired with no other transfer, a poll is answered with the device address. A following data strobe returns the same key code with the keyboard acknowledge held at 0.
- R9: Repeats are spaced by the oscillator period (`CLK_HZ/REP_HZ` cycles). Just after a repeat transfer, a poll is ignored until the next tick has passed through the three sequencer stages.
- R10: A new keyboard strobe stops repeating. The new code is transferred with an acknowledge, and no repeat is offered within the new hold-off time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_strobe_i | input | 1 | Keyboard has a character waiting (level) |
| kb_code_i | input | DATA_W | Key code from keyboard |
| poll_i | input | 1 | CPU poll |
| iod_i | input | 1 | CPU I/O data strobe |
| kb_ack_o | output | 1 | Acknowledge to keyboard |
| bus_data_o | output | DATA_W | Value offered to the data bus |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest state to reach is a repeat request that is pending while hold-off and oscillator timing are both running. With default timers this takes millions of cycles. The bench shrinks `CLK_HZ` so that the hold-off is 600 cycles and the repeat period is 80 cycles. It then polls before expiry, shortly after expiry, right after a repeat, and one period later. This shows both the gate and the spacing from the ports alone.

// File: rtl/kbh_pkg.sv
package kbh_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_SEL  = 2'd1,
    HS_XFER = 2'd2,
    HS_ACKW = 2'd3
  } hs_state_e;
endpackage

// File: rtl/kbh_handshake.sv
module kbh_handshake
  import kbh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] DEV_ADDR = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_strobe_i,
  input  logic [DATA_W-1:0] kb_code_i,
  input  logic              poll_i,
  input  logic              iod_i,
  input  logic              rep_req_i,
  output logic              kb_rise_o,
  output logic              claim_o,
  output logic              claim_rep_o,
  output logic              kb_done_o,
  output logic              kb_ack_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o
);
  hs_state_e         st;
  logic              strobe_q;
  logic              rep_xfer;
  logic [DATA_W-1:0] code_q;

  assign kb_rise_o   = kb_strobe_i && !strobe_q;
  assign claim_o     = (st == HS_IDLE) && poll_i && (kb_strobe_i || rep_req_i);
  assign claim_rep_o = claim_o && !kb_strobe_i;
  assign kb_done_o   = (st == HS_ACKW) && !kb_strobe_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= HS_IDLE;
      strobe_q <= 1'b0;
      rep_xfer <= 1'b0;
      code_q   <= '0;
    end else begin
      strobe_q <= kb_strobe_i;
      unique case (st)
        HS_IDLE: if (claim_o) begin
          st       <= HS_SEL;
          rep_xfer <= !kb_strobe_i;
          if (kb_strobe_i) code_q <= kb_code_i;
        end
        HS_SEL:  if (iod_i) st <= HS_XFER;
        HS_XFER: if (!iod_i) st <= rep_xfer ? HS_IDLE : HS_ACKW;
        HS_ACKW: if (!kb_strobe_i) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign bus_oe_o   = (st == HS_SEL) || (st == HS_XFER);
  assign bus_data_o = (st == HS_XFER) ? code_q : DEV_ADDR;
  assign kb_ack_o   = ((st == HS_XFER) && !rep_xfer) || (st == HS_ACKW);

  // R8: a repeat transfer never acknowledges the keyboard
  a_r8_rep_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_XFER && rep_xfer) |-> !kb_ack_o);
  // R4: address phase persists until the data strobe
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_SEL && !iod_i) |=> (st == HS_SEL));
endmodule

// File: rtl/kbh_holdoff.sv
module kbh_holdoff #(
  parameter int HOLD_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cancel_i,
  input  logic stop_i,
  output logic rep_en_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] cnt;
  logic          active;
  logic          expire;

  assign expire = active && !cancel_i && !start_i && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      active   <= 1'b0;
      rep_en_o <= 1'b0;
    end else begin
      if (cancel_i) active <= 1'b0;
      else if (start_i) begin
        active <= 1'b1;
        cnt    <= HW'(HOLD_CYC - 1);
      end else if (active) begin
        if (cnt == '0) active <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
      if (stop_i) rep_en_o <= 1'b0;
      else if (expire) rep_en_o <= 1'b1;
    end
  end

  // R7: repeat enable is never up while the hold-off is still timing
  a_r7_no_en_in_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !rep_en_o);
endmodule

// File: rtl/kbh_repeat_seq.sv
module kbh_repeat_seq #(
  parameter int REP_CYC = 80,
  parameter int STAGES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic claim_i,
  output logic req_o
);
  localparam int RW = $clog2(REP_CYC + 1);
  logic [RW-1:0]     div;
  logic              tick;
  logic [STAGES-1:0] sr;

  assign tick = en_i && (div == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) div <= RW'(REP_CYC - 1);
    else if (tick) div <= RW'(REP_CYC - 1);
    else div <= div - 1'b1;
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n || !en_i) sr[i] <= 1'b0;
      else if (i == 0) sr[i] <= tick;
      else sr[i] <= sr[(i > 0) ? i - 1 : 0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) req_o <= 1'b0;
    else if (sr[STAGES-1]) req_o <= 1'b1;
    else if (claim_i) req_o <= 1'b0;
  end

  // R9: a request only appears after a tick has left the last stage
  a_r9_req_from_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(sr[STAGES-1]));
  // R9: the ticks are far apart, so at most one is in the sequencer
  a_r9_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (REP_CYC > STAGES) |-> $onehot0(sr));
endmodule

// File: rtl/kbd_autorepeat.sv
module kbd_autorepeat #(
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEV_ADDR = 8'h2C,
  parameter int CLK_HZ   = 125_000_000,
  parameter int HOLD_DIV = 2,
  parameter int REP_HZ   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_strobe_i,
  input  logic [DATA_W-1:0] kb_code_i,
  input  logic              poll_i,
  input  logic              iod_i,
  output logic              kb_ack_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o
);
  localparam int HOLD_CYC = CLK_HZ / HOLD_DIV;
  localparam int REP_CYC  = CLK_HZ / REP_HZ;

  logic kb_rise, claim, claim_rep, kb_done, rep_en, rep_req;

  kbh_handshake #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_hs (
    .clk, .rst_n, .kb_strobe_i, .kb_code_i, .poll_i, .iod_i,
    .rep_req_i(rep_req), .kb_rise_o(kb_rise), .claim_o(claim),
    .claim_rep_o(claim_rep), .kb_done_o(kb_done),
    .kb_ack_o, .bus_data_o, .bus_oe_o);

  kbh_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk, .rst_n, .start_i(kb_done), .cancel_i(kb_rise || claim),
    .stop_i(kb_rise), .rep_en_o(rep_en));

  kbh_repeat_seq #(.REP_CYC(REP_CYC), .STAGES(3)) u_rep (
    .clk, .rst_n, .en_i(rep_en), .claim_i(claim_rep), .req_o(rep_req));

  // R3: the bus is only taken up in answer to a poll
  a_r3_oe_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(poll_i));
  // R6: acknowledge is dropped only once the keyboard strobe is low
  a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_ack_o) |-> !$past(kb_strobe_i));
endmodule

// File: tb/kbd_autorepeat_tb_top.sv
module kbd_autorepeat_tb_top;
  localparam int DW = 8;
  localparam logic [DW-1:0] ADDR = 8'h2C;
  localparam int CLK_HZ = 1200;
  localparam int HOLD = CLK_HZ / 2;
  localparam int REP  = CLK_HZ / 15;
  localparam logic [DW-1:0] KEYS [5] = '{8'h41, 8'h00, 8'hFF, 8'h2C, 8'h5A};

  logic clk = 1'b0, rst_n = 1'b0;
  logic kb_strobe = 1'b0, poll = 1'b0, iod = 1'b0;
  logic [DW-1:0] kb_code = '0;
  logic kb_ack, bus_oe;
  logic [DW-1:0] bus_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbd_autorepeat #(.DATA_W(DW), .DEV_ADDR(ADDR), .CLK_HZ(CLK_HZ)) dut_i (
    .clk, .rst_n, .kb_strobe_i(kb_strobe), .kb_code_i(kb_code),
    .poll_i(poll), .iod_i(iod), .kb_ack_o(kb_ack),
    .bus_data_o(bus_data), .bus_oe_o(bus_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one poll pulse; reports whether the bus was claimed
  task automatic poll_once(output bit claimed);
    poll = 1'b1; cyc(1); poll = 1'b0;
    claimed = bus_oe;
  endtask

  task automatic key_xfer(input logic [DW-1:0] code, input int hold_sel);
    bit c;
    kb_code = code; kb_strobe = 1'b1;
    poll_once(c);
    chk(c && bus_data == ADDR, "R3 address phase", bus_data, ADDR);
    cyc(hold_sel);
    chk(bus_oe && bus_data == ADDR, "R4 address held", bus_data, ADDR);
    iod = 1'b1; cyc(1);
    chk(bus_oe && bus_data == code, "R5 key code", bus_data, code);
    chk(kb_ack == 1'b1, "R5 ack raised", kb_ack, 1);
    iod = 1'b0; cyc(1);
    chk(!bus_oe && kb_ack, "R6 bus released, ack held", {bus_oe, kb_ack}, 2'b01);
    cyc(2);
    chk(kb_ack == 1'b1, "R6 ack waits for strobe", kb_ack, 1);
    kb_strobe = 1'b0; cyc(1);
    chk(kb_ack == 1'b0, "R6 ack dropped", kb_ack, 0);
  endtask

  task automatic rep_xfer(input logic [DW-1:0] code, input string tag);
    bit c;
    poll_once(c);
    chk(c && bus_data == ADDR, {tag, " repeat address"}, bus_data, ADDR);
    iod = 1'b1; cyc(1);
    chk(bus_oe && bus_data == code, {tag, " repeat code"}, bus_data, code);
    chk(kb_ack == 1'b0, {tag, " repeat without ack"}, kb_ack, 0);
    iod = 1'b0; cyc(1);
    chk(!bus_oe, {tag, " repeat bus released"}, bus_oe, 0);
  endtask

  initial begin
    bit c;
    cyc(3);
    chk(!bus_oe && !kb_ack, "R1 reset state", {bus_oe, kb_ack}, 0);
    rst_n = 1'b1; cyc(1);
    chk(!bus_oe && !kb_ack, "R1 after reset", {bus_oe, kb_ack}, 0);
    poll_once(c); cyc(1);
    chk(!c && !bus_oe, "R2 poll ignored", bus_oe, 0);

    foreach (KEYS[i]) begin
      key_xfer(KEYS[i], i);
      cyc(5);
    end

    // R7 / R8: hold-off gating, then a repeat of the last key
    key_xfer(8'h37, 0);
    cyc(HOLD - 20);
    poll_once(c);
    chk(!c, "R7 no repeat before hold-off", c, 0);
    cyc(REP + 40);
    rep_xfer(8'h37, "R8");
    // R9: spacing of repeats
    poll_once(c);
    chk(!c, "R9 no repeat right after repeat", c, 0);
    cyc(REP + 5);
    rep_xfer(8'h37, "R9");

    // R10: new key stops repeating
    key_xfer(8'h62, 0);
    cyc(HOLD - 20);
    poll_once(c);
    chk(!c, "R10 repeat stopped by new key", c, 0);
    cyc(REP + 40);
    rep_xfer(8'h62, "R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule